// File: doc/BRIEF.md
# Register-Driven Interrupt Configuration Invalidation Controller

This block turns a single register write into an invalidate request towards a cache of interrupt configuration. A write names an operation kind (flush one interrupt ID, or flush every ID) and an ID space. With the space selector at 0 the physical ID space is meant. With the selector at 1 the space is that of the virtual processing element (vPE) named in the write. The block forwards one request to the cache side and then waits for a one-cycle acknowledge. Until that acknowledge arrives it shows a busy flag, which software polls to learn when the flush is done.

A virtual single-ID flush only makes sense for message-signalled IDs (8192 and up) that lie inside the range supported by the named vPE. The upper bound of each vPE's range comes from a configuration table input. A virtual single-ID write that falls outside these bounds is dropped silently. It raises no request and leaves busy low. A write that arrives while busy is high is discarded.

Top module: `inv_ctrl`

## Requirements
- R1: After reset, `busy` and `inv_req` are 0.
- R2: An accepted write with `wr_virt`=0 and `wr_all`=0 issues a request for any `wr_id`, including IDs below 8192. The request has `inv_virt`=0, `inv_all`=0, `inv_vpe`=0 and `inv_id`=`wr_id`.
- R3: A write with `wr_virt`=1 and `wr_all`=0 and with 8192 <= `wr_id` < limit of vPE `wr_vpe` issues a request with `inv_virt`=1, `inv_all`=0, `inv_vpe`=`wr_vpe` and `inv_id`=`wr_id`. The limit of vPE k is bits [k*ID_W +: ID_W] of `vpe_id_limit`, and it is exclusive.
- R4: A virtual single-ID write with `wr_id` < 8192 has no effect: no request is issued and `busy` stays 0.
- R5: A virtual single-ID write with `wr_id` >= the limit of its vPE has no effect: no request is issued and `busy` stays 0.
- R6: A write with `wr_all`=1 is always issued, for either space. The request has `inv_all`=1 and `inv_id`=0. `inv_vpe` equals `wr_vpe` when `wr_virt`=1 and is 0 otherwise.
- R7: `inv_req` is high for exactly the one cycle after the clock edge that accepts a write. `busy` is 1 from that same cycle until completion.
- R8: When `inv_ack` is sampled high while waiting, `busy` is 0 from the next cycle on.
- R9: A write sampled while `busy` is 1 is ignored. The request fields hold their values, and no further request follows completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe, one cycle |
| wr_all | input | 1 | 1: invalidate all IDs, 0: one ID |
| wr_virt | input | 1 | 1: virtual ID space of `wr_vpe`, 0: physical |
| wr_vpe | input | VPE_W | Target vPE number |
| wr_id | input | ID_W | Interrupt ID for single-ID operations |
| vpe_id_limit | input | NUM_VPE*ID_W | Per-vPE exclusive upper bound of supported IDs |
| busy | output | 1 | Readable busy flag |
| inv_req | output | 1 | One-cycle invalidate request to the cache |
| inv_all | output | 1 | Request kind: all IDs |
| inv_virt | output | 1 | Request space: virtual |
| inv_vpe | output | VPE_W | Request vPE |
| inv_id | output | ID_W | Request ID |
| inv_ack | input | 1 | One-cycle completion acknowledge from the cache |

## Verification
The checker assumes that the cache never acknowledges in the same cycle as the request. It also assumes that the cache acknowledges only while the block waits, and that the limit table is held steady while an operation is in flight. The stimulus meets these conditions in three ways. It drives the limits once before reset is released. It raises `inv_ack` only after `inv_req` has fallen and `busy` has been observed high. It drives every write strobe for exactly one cycle.

// File: rtl/inv_pkg.sv
package inv_pkg;
  // First message-signalled interrupt ID
  localparam int unsigned MSI_FIRST = 8192;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } inv_state_e;
endpackage

// File: rtl/inv_filter.sv
module inv_filter #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VPE_W = 2,
  localparam int unsigned NUM_VPE = 1 << VPE_W
) (
  input  logic                      op_all,
  input  logic                      op_virt,
  input  logic [VPE_W-1:0]          op_vpe,
  input  logic [ID_W-1:0]           op_id,
  input  logic [NUM_VPE*ID_W-1:0]   vpe_id_limit,
  output logic                      op_keep
);
  import inv_pkg::*;

  logic [ID_W-1:0] limit_arr [NUM_VPE];

  for (genvar k = 0; k < NUM_VPE; k++) begin : g_lim
    assign limit_arr[k] = vpe_id_limit[k*ID_W +: ID_W];
  end

  logic [31:0] id_ext;
  logic [31:0] lim_ext;
  logic        below_msi;
  logic        above_lim;

  always_comb begin
    id_ext    = 32'(op_id);
    lim_ext   = 32'(limit_arr[op_vpe]);
    below_msi = id_ext < MSI_FIRST;
    above_lim = id_ext >= lim_ext;
    op_keep   = op_all || !op_virt || !(below_msi || above_lim);
  end
endmodule

// File: rtl/inv_seq.sv
module inv_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic load,
  output logic req,
  output logic busy
);
  import inv_pkg::*;

  inv_state_e state_q;
  inv_state_e state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ISSUE;
          load    = 1'b1;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req  = (state_q == ST_ISSUE);
  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/inv_hold.sv
module inv_hold #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VPE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             d_all,
  input  logic             d_virt,
  input  logic [VPE_W-1:0] d_vpe,
  input  logic [ID_W-1:0]  d_id,
  output logic             q_all,
  output logic             q_virt,
  output logic [VPE_W-1:0] q_vpe,
  output logic [ID_W-1:0]  q_id
);
  logic [VPE_W-1:0] vpe_n;
  logic [ID_W-1:0]  id_n;

  always_comb begin
    vpe_n = d_virt ? d_vpe : '0;
    id_n  = d_all  ? '0    : d_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_all  <= 1'b0;
      q_virt <= 1'b0;
      q_vpe  <= '0;
      q_id   <= '0;
    end else if (en) begin
      q_all  <= d_all;
      q_virt <= d_virt;
      q_vpe  <= vpe_n;
      q_id   <= id_n;
    end
  end
endmodule

// File: rtl/inv_ctrl.sv
module inv_ctrl #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VPE_W = 2,
  localparam int unsigned NUM_VPE = 1 << VPE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic                    wr_all,
  input  logic                    wr_virt,
  input  logic [VPE_W-1:0]        wr_vpe,
  input  logic [ID_W-1:0]         wr_id,
  input  logic [NUM_VPE*ID_W-1:0] vpe_id_limit,
  output logic                    busy,
  output logic                    inv_req,
  output logic                    inv_all,
  output logic                    inv_virt,
  output logic [VPE_W-1:0]        inv_vpe,
  output logic [ID_W-1:0]         inv_id,
  input  logic                    inv_ack
);
  logic keep;
  logic start;
  logic load;

  inv_filter #(.ID_W(ID_W), .VPE_W(VPE_W)) u_filter (
    .op_all       (wr_all),
    .op_virt      (wr_virt),
    .op_vpe       (wr_vpe),
    .op_id        (wr_id),
    .vpe_id_limit (vpe_id_limit),
    .op_keep      (keep)
  );

  assign start = wr_valid && keep;

  inv_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ack   (inv_ack),
    .load  (load),
    .req   (inv_req),
    .busy  (busy)
  );

  inv_hold #(.ID_W(ID_W), .VPE_W(VPE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (load),
    .d_all  (wr_all),
    .d_virt (wr_virt),
    .d_vpe  (wr_vpe),
    .d_id   (wr_id),
    .q_all  (inv_all),
    .q_virt (inv_virt),
    .q_vpe  (inv_vpe),
    .q_id   (inv_id)
  );
endmodule

// File: rtl/inv_ctrl_chk.sv
module inv_ctrl_chk #(
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VPE_W = 2,
  localparam int unsigned NUM_VPE = 1 << VPE_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    inv_req,
  input logic                    inv_all,
  input logic                    inv_virt,
  input logic [VPE_W-1:0]        inv_vpe,
  input logic [ID_W-1:0]         inv_id,
  input logic                    inv_ack,
  input logic [NUM_VPE*ID_W-1:0] vpe_id_limit
);
  logic [ID_W-1:0] req_lim;
  assign req_lim = vpe_id_limit[inv_vpe*ID_W +: ID_W];

  // R7: the request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> !inv_req);

  // R7: busy is high whenever a request is out
  p_busy_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> busy);

  // R7: busy rises only together with a request
  p_rise_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> inv_req);

  // R8: acknowledge while waiting ends the operation
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !inv_req && inv_ack) |=> !busy);

  // R9: fields hold while the operation is in flight
  p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !inv_req) |-> ($stable(inv_id) && $stable(inv_vpe)
                            && $stable(inv_all) && $stable(inv_virt)));

  // R3, R4, R5: issued virtual single-ID requests are in range
  p_virt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_virt && !inv_all) |->
      (32'(inv_id) >= 32'd8192 && inv_id < req_lim));

  // R6: flush-all requests carry a zero ID
  p_all_zero_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_all) |-> (inv_id == '0));
endmodule

bind inv_ctrl inv_ctrl_chk #(.ID_W(ID_W), .VPE_W(VPE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .inv_req      (inv_req),
  .inv_all      (inv_all),
  .inv_virt     (inv_virt),
  .inv_vpe      (inv_vpe),
  .inv_id       (inv_id),
  .inv_ack      (inv_ack),
  .vpe_id_limit (vpe_id_limit)
);

// File: tb/inv_ctrl_tb_top.sv
module inv_ctrl_tb_top;
  localparam int ID_W  = 16;
  localparam int VPE_W = 2;
  localparam int NV    = 1 << VPE_W;

  logic                 clk;
  logic                 rst_n;
  logic                 wr_valid;
  logic                 wr_all;
  logic                 wr_virt;
  logic [VPE_W-1:0]     wr_vpe;
  logic [ID_W-1:0]      wr_id;
  logic [NV*ID_W-1:0]   vpe_id_limit;
  logic                 busy;
  logic                 inv_req;
  logic                 inv_all;
  logic                 inv_virt;
  logic [VPE_W-1:0]     inv_vpe;
  logic [ID_W-1:0]      inv_id;
  logic                 inv_ack;

  int n_chk;
  int n_fail;
  bit done;

  inv_ctrl #(.ID_W(ID_W), .VPE_W(VPE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_all(wr_all),
    .wr_virt(wr_virt), .wr_vpe(wr_vpe), .wr_id(wr_id),
    .vpe_id_limit(vpe_id_limit), .busy(busy), .inv_req(inv_req),
    .inv_all(inv_all), .inv_virt(inv_virt), .inv_vpe(inv_vpe),
    .inv_id(inv_id), .inv_ack(inv_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lim_of(int v);
    case (v)
      0: return 8192;
      1: return 8200;
      2: return 9000;
      default: return 65535;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit all, input bit virt, input int vpe, input int id);
    bit drop;
    int e_vpe;
    int e_id;
    drop  = !all && virt && (id < 8192 || id >= lim_of(vpe));
    e_vpe = virt ? vpe : 0;
    e_id  = all ? 0 : id;
    @(negedge clk);
    wr_valid = 1'b1; wr_all = all; wr_virt = virt;
    wr_vpe = VPE_W'(vpe); wr_id = ID_W'(id);
    @(negedge clk);
    wr_valid = 1'b0;
    if (drop) begin
      chk(!inv_req && !busy, virt && id < 8192 ? "R4 dropped" : "R5 dropped",
          int'(busy), 0);
      @(negedge clk);
      chk(!inv_req && !busy, "R5 still idle", int'(inv_req), 0);
      return;
    end
    chk(inv_req && busy, "R7 request", int'(inv_req), 1);
    chk(inv_all == all && inv_virt == virt, all ? "R6 kind" : (virt ? "R3 kind" : "R2 kind"),
        int'({inv_all, inv_virt}), int'({all, virt}));
    chk(int'(inv_vpe) == e_vpe, all ? "R6 vpe" : "R3 vpe", int'(inv_vpe), e_vpe);
    chk(int'(inv_id) == e_id, all ? "R6 id" : "R2 id", int'(inv_id), e_id);
    @(negedge clk);
    chk(!inv_req && busy, "R7 waiting", int'(busy), 1);
    // intruding write while busy
    wr_valid = 1'b1; wr_all = ~all; wr_virt = 1'b0; wr_id = ID_W'(id ^ 16'h00f0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(busy && !inv_req && int'(inv_id) == e_id && inv_all == all, "R9 hold",
        int'(inv_id), e_id);
    inv_ack = 1'b1;
    @(negedge clk);
    inv_ack = 1'b0;
    chk(!busy && !inv_req, "R8 done", int'(busy), 0);
    @(negedge clk);
    chk(!busy && !inv_req, "R9 no replay", int'(inv_req), 0);
  endtask

  initial begin
    int ids [6];
    n_chk = 0; n_fail = 0; done = 1'b0;
    wr_valid = 1'b0; wr_all = 1'b0; wr_virt = 1'b0; wr_vpe = '0; wr_id = '0;
    inv_ack = 1'b0;
    for (int k = 0; k < NV; k++) vpe_id_limit[k*ID_W +: ID_W] = ID_W'(lim_of(k));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !inv_req, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !inv_req, "R1 after release", int'(inv_req), 0);
    for (int v = 0; v < NV; v++) begin
      ids[0] = 0; ids[1] = 8191; ids[2] = 8192;
      ids[3] = lim_of(v) - 1; ids[4] = lim_of(v); ids[5] = 65535;
      for (int i = 0; i < 6; i++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++)
            run_op(a[0], s[0], v, ids[i]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule